// File: doc/BRIEF.md
# Fine-Grained Multithreaded Issue Scheduler

This block selects one thread context per clock cycle from a pool of thread contexts and issues one instruction for it into a deep execution pipeline. A context can be chosen when software has enabled it, its ready flag is set and it has no instruction in flight. Once chosen, the context is marked busy until the pipeline reports that its instruction has retired. Because each thread can have only one instruction in flight, the pipeline needs no hazard detection, forwarding or branch prediction. This single rule is enough for correct execution.

The selection is round-robin. The search starts at the ID just after the most recently issued thread. The issue decision is combinational from the current inputs and the busy state. Busy state and the round-robin pointer are registered. The scheduler handles only thread IDs. The register contents of a context (an accumulator and sixteen general registers) are held elsewhere.

Top module: `thread_issue_sched`

## Requirements
- R1: At most one thread ID is issued per cycle. `issue_valid_o` qualifies `issue_tid_o`.
- R2: An issued thread has both its `thread_valid_i` bit and its `thread_ready_i` bit set in the issue cycle.
- R3: A thread issued in cycle t is busy from cycle t+1 onward. It is not issued again until a retire for its ID has been accepted.
- R4: A retire for a busy thread in cycle t makes that thread eligible from cycle t+1.
- R5: The scheduler issues the first eligible ID that follows the most recently issued ID, searching upward and wrapping past NUM_THREADS-1 to 0.
- R6: While `stall_i` is high, nothing is issued and the round-robin pointer keeps its value.
- R7: A retire naming a thread that is not busy has no effect.
- R8: Clearing a thread's valid bit while it is busy does not lose its busy state. Its later retire is still accepted, and the thread becomes eligible again once it is re-enabled.
- R9: After reset no thread is busy and the pointer is at NUM_THREADS-1. The first issue therefore goes to the lowest eligible ID.
- R10: When stall is low and any thread is eligible, a thread is issued in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thread_valid_i | input | NUM_THREADS | Per-thread enable mask |
| thread_ready_i | input | NUM_THREADS | Per-thread ready flag |
| stall_i | input | 1 | Holds off issue this cycle |
| retire_valid_i | input | 1 | A retire is reported this cycle |
| retire_tid_i | input | TID_W | ID of the retiring thread |
| issue_valid_o | output | 1 | An instruction is issued this cycle |
| issue_tid_o | output | TID_W | ID of the issued thread |

## Verification
The assertions assume that the pipeline reports a retire only for a thread that actually has an instruction in flight, with the one exception that R7 deliberately tests. They also assume that `retire_tid_i` is always below NUM_THREADS. The bench runs a four-thread configuration and keeps its own model of which threads are busy. Most retires name a thread that the model marks as busy. A small, deliberate fraction name an idle thread to exercise R7. Every retire ID is drawn from the legal range.

// File: rtl/sched_pkg.sv
package sched_pkg;
  localparam int unsigned DEF_THREADS = 64;

  function automatic int unsigned tid_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sched_rr_pick.sv
module sched_rr_pick #(
  parameter int unsigned N  = 64,
  parameter int unsigned TW = 6
) (
  input  logic [N-1:0]  elig_i,
  input  logic [TW-1:0] last_i,
  output logic          found_o,
  output logic [TW-1:0] pick_o
);
  int unsigned idx;

  // scan upward from the slot after last_i, wrapping once
  always_comb begin
    found_o = 1'b0;
    pick_o  = '0;
    idx     = 0;
    for (int unsigned k = 1; k <= N; k++) begin
      idx = (int'(last_i) + k) % N;
      if (!found_o && elig_i[idx]) begin
        found_o = 1'b1;
        pick_o  = TW'(idx);
      end
    end
  end
endmodule

// File: rtl/sched_busy_track.sv
module sched_busy_track #(
  parameter int unsigned N  = 64,
  parameter int unsigned TW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en_i,
  input  logic [TW-1:0] set_id_i,
  input  logic          clr_en_i,
  input  logic [TW-1:0] clr_id_i,
  output logic [N-1:0]  busy_o
);
  logic [N-1:0] busy_q;
  logic [N-1:0] busy_d;

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic hit_set;
    logic hit_clr;
    assign hit_set = set_en_i && (set_id_i == TW'(g));
    assign hit_clr = clr_en_i && (clr_id_i == TW'(g));
    // retire applied first, new issue then marks the slot
    always_comb begin
      busy_d[g] = busy_q[g];
      if (hit_clr) busy_d[g] = 1'b0;
      if (hit_set) busy_d[g] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= '0;
    else        busy_q <= busy_d;
  end

  assign busy_o = busy_q;

  // R3
  busy_after_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en_i |=> busy_q[$past(set_id_i)]);
  // R4
  free_after_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en_i && !(set_en_i && set_id_i == clr_id_i)) |=> !busy_q[$past(clr_id_i)]);
endmodule

// File: rtl/thread_issue_sched.sv
module thread_issue_sched
  import sched_pkg::*;
#(
  parameter int unsigned NUM_THREADS = DEF_THREADS,
  parameter int unsigned TID_W       = tid_width(NUM_THREADS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_THREADS-1:0] thread_valid_i,
  input  logic [NUM_THREADS-1:0] thread_ready_i,
  input  logic                   stall_i,
  input  logic                   retire_valid_i,
  input  logic [TID_W-1:0]       retire_tid_i,
  output logic                   issue_valid_o,
  output logic [TID_W-1:0]       issue_tid_o
);
  localparam logic [TID_W-1:0] PTR_INIT = TID_W'(NUM_THREADS - 1);

  logic [NUM_THREADS-1:0] busy;
  logic [NUM_THREADS-1:0] elig;
  logic                   found;
  logic [TID_W-1:0]       pick;
  logic [TID_W-1:0]       ptr_q;
  logic [TID_W-1:0]       ptr_d;
  logic                   ptr_en;

  assign elig = thread_valid_i & thread_ready_i & ~busy;

  sched_rr_pick #(.N(NUM_THREADS), .TW(TID_W)) u_pick (
    .elig_i  (elig),
    .last_i  (ptr_q),
    .found_o (found),
    .pick_o  (pick)
  );

  assign issue_valid_o = found && !stall_i;
  assign issue_tid_o   = pick;

  sched_busy_track #(.N(NUM_THREADS), .TW(TID_W)) u_busy (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en_i (issue_valid_o),
    .set_id_i (pick),
    .clr_en_i (retire_valid_i),
    .clr_id_i (retire_tid_i),
    .busy_o   (busy)
  );

  assign ptr_en = issue_valid_o;

  always_comb begin
    ptr_d = ptr_q;
    if (ptr_en) ptr_d = pick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= PTR_INIT;
    else        ptr_q <= ptr_d;
  end

  // R2
  issue_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid_o |-> (thread_valid_i[issue_tid_o] && thread_ready_i[issue_tid_o]));
  // R3
  no_double_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid_o |-> !busy[issue_tid_o]);
  // R6
  stall_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |-> !issue_valid_o);
  // R6
  stall_ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> $stable(ptr_q));
  // R10
  work_conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_i && (|elig)) |-> issue_valid_o);
endmodule

// File: tb/thread_issue_sched_tb.sv
module thread_issue_sched_tb;
  localparam int unsigned N  = 4;
  localparam int unsigned TW = 2;

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  v_i;
  logic [N-1:0]  r_i;
  logic          st_i;
  logic          rv_i;
  logic [TW-1:0] rt_i;
  logic          iv_o;
  logic [TW-1:0] it_o;

  int checks = 0;
  int errors = 0;
  logic [N-1:0]  busy_m;
  logic [TW-1:0] ptr_m;

  thread_issue_sched #(.NUM_THREADS(N), .TID_W(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .thread_valid_i(v_i), .thread_ready_i(r_i),
    .stall_i(st_i), .retire_valid_i(rv_i), .retire_tid_i(rt_i),
    .issue_valid_o(iv_o), .issue_tid_o(it_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  task automatic step(input logic [N-1:0] v, input logic [N-1:0] r, input logic st,
                      input logic rv, input logic [TW-1:0] rt, input string req);
    logic          ev;
    logic [TW-1:0] et;
    logic [N-1:0]  el;
    @(negedge clk);
    v_i = v; r_i = r; st_i = st; rv_i = rv; rt_i = rt;
    #1;
    el = v & r & ~busy_m;
    ev = 1'b0; et = '0;
    for (int k = 1; k <= N; k++) begin
      int unsigned j;
      j = (int'(ptr_m) + k) % N;
      if (!ev && el[j] && !st) begin ev = 1'b1; et = TW'(j); end
    end
    checks++;
    if (iv_o !== ev || (ev && it_o !== et)) begin
      errors++;
      $display("FAIL %s: actual valid=%0b tid=%0d expected valid=%0b tid=%0d",
               req, iv_o, it_o, ev, et);
    end
    if (rv) busy_m[rt] = 1'b0;
    if (ev) begin busy_m[et] = 1'b1; ptr_m = et; end
  endtask

  initial begin
    rst_n = 1'b0; v_i = '0; r_i = '0; st_i = 1'b0; rv_i = 1'b0; rt_i = '0;
    busy_m = '0; ptr_m = TW'(N - 1);
    #12 rst_n = 1'b1;
    // R9: nothing enabled, nothing issued
    step('0, '1, 1'b0, 1'b0, 0, "R9");
    // R9 R5: first issue to lowest, then in order
    step('1, '1, 1'b0, 1'b0, 0, "R9");
    step('1, '1, 1'b0, 1'b0, 0, "R5");
    step('1, '1, 1'b0, 1'b0, 0, "R5");
    step('1, '1, 1'b0, 1'b0, 0, "R5");
    // R3: all busy, none issued
    step('1, '1, 1'b0, 1'b0, 0, "R3");
    // R4: retire 2, eligible next cycle
    step('1, '1, 1'b0, 1'b1, 2, "R4");
    step('1, '1, 1'b0, 1'b0, 0, "R4");
    // R6: stall while 0 becomes free
    step('1, '1, 1'b1, 1'b1, 0, "R6");
    step('1, '1, 1'b1, 1'b0, 0, "R6");
    step('1, '1, 1'b0, 1'b0, 0, "R6");
    // R8: disable thread 1 while busy, retire, re-enable
    step(4'b1101, '1, 1'b0, 1'b1, 1, "R8");
    step(4'b1101, '1, 1'b0, 1'b0, 0, "R8");
    step('1, '1, 1'b0, 1'b0, 0, "R8");
    // R7: retire of an idle thread ignored
    step('1, '1, 1'b0, 1'b1, 3, "R4");
    step(4'b0111, '1, 1'b0, 1'b1, 3, "R7");
    step('1, '1, 1'b0, 1'b0, 0, "R7");
    step('1, '1, 1'b0, 1'b0, 0, "R7");
    // R2: ready low blocks a free thread
    step('1, '1, 1'b0, 1'b1, 0, "R2");
    step('1, 4'b1110, 1'b0, 1'b0, 0, "R2");
    step('1, 4'b1111, 1'b0, 1'b0, 0, "R2");
    // R1 R5 R10: mixed sweep
    for (int c = 0; c < 4000; c++) begin
      logic [TW-1:0] pick;
      logic          rv;
      pick = TW'($urandom_range(N - 1));
      rv   = 1'b0;
      if ($urandom_range(9) == 0) rv = 1'b1;
      else if (busy_m != '0) begin
        for (int s = 0; s < N; s++) begin
          if (busy_m[pick]) begin rv = ($urandom_range(2) != 0); break; end
          pick = pick + 1'b1;
        end
      end
      step(N'($urandom), N'($urandom | $urandom), ($urandom_range(7) == 0),
           rv, pick, "R1 R5 R10");
    end
    finish_run();
  end
endmodule